// File: doc/BRIEF.md
# Thermal Limit Alarm Register Block

This block is the register-side half of an on-board temperature monitor. A sensor front end delivers signed 11-bit readings in quarter-degree steps together with a one-cycle valid strobe. The block keeps the most recent reading and compares every accepted reading against four host-programmable limits: upper, lower, upper-critical and lower-critical. Each violated limit sets a status bit that stays set until the host clears it.

The host reaches the block over a byte-wide register port. Writes are strobed and reads are combinational from the address. Readings and limits appear as 16-bit little-endian byte pairs. The value sits in bits [12:2], and bits [1:0] and [15:13] read as zero. A single configuration bit stops the block from accepting samples. A fixed capability byte reports that a sensor is present. A page-select byte is kept for the host's paging scheme. Writes to any other address leave the block's state unchanged.

Top module: `thermal_limit_regs`

## Requirements
- R1: After reset, every limit, the reading, the status byte, the configuration byte and the page byte read 0x00, and the capability byte at 0x05 reads 0x02, which means a sensor is present.
- R2: An accepted sample of value v reads back at 0x31 (low byte) and 0x32 (high byte) as the 16-bit word {3'b000, v[10:0], 2'b00}. This covers both extremes, -1024 and +1023.
- R3: The limit pairs are upper at 0x1C/0x1D, lower at 0x1E/0x1F, upper-critical at 0x20/0x21 and lower-critical at 0x22/0x23. A low-byte write stores data bits [7:2] and a high-byte write stores data bits [4:0]. Readback shows zeros in word bits [1:0] and [15:13].
- R4: For an accepted sample, status bit 0 sets when the sample is strictly greater than the upper limit, and status bit 1 sets when it is strictly less than the lower limit. Both comparisons are signed, so a sample equal to a limit sets nothing.
- R5: For an accepted sample, status bit 2 sets when the sample is strictly greater than the upper-critical limit, and status bit 3 sets when it is strictly less than the lower-critical limit. The status byte is read at 0x33.
- R6: Status bits are sticky. Writing a mask to 0x13 clears exactly the status bits whose mask bit is 1. Addresses 0x13 and 0x14 always read 0x00.
- R7: If a clear write and an accepted sample that violates a limit fall in the same cycle, the status bit for that limit ends up set.
- R8: Bit 0 of the configuration byte at 0x1A disables the sensor, and the other bits of that byte read zero. While the bit is 1, samples change neither the reading nor the status.
- R9: Writes to 0x31, 0x32, 0x33, 0x05 and 0x14 change no readable value.
- R10: The page byte at 0x0B stores data bits [3:0], and its bits [7:4] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe from the sensor front end |
| smp_value | input | 11 | Signed sample, 0.25 degree per LSB |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |

## Verification
On every cycle, the embedded assertions check the following:
- Alarm bits stay set unless a clear mask removes them.
- A clear never beats a simultaneous upper-limit violation.
- A disabled sensor neither moves the reading nor raises new alarms.
- The padding bits of the reading and the reserved configuration bits read zero.

Only the bench scenarios can show the rest, because those checks need known stimulus and a computed expected value:
- The correctness of the signed comparisons, including the equal-to-limit boundary.
- The exact byte packing of negative and extreme readings.
- Limit write masking.
- The read-only behaviour of the status, reading and capability addresses.

// File: rtl/thermal_limit_regs.sv
module thermal_limit_regs #(
  parameter int TW = 11,
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [TW-1:0] smp_value,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);

  localparam int NLIM = 4;
  localparam int LOW_BITS = DW - 2;
  localparam int HIGH_BITS = TW - LOW_BITS;

  localparam logic [AW-1:0] A_CAP    = AW'(8'h05);
  localparam logic [AW-1:0] A_PAGE   = AW'(8'h0B);
  localparam logic [AW-1:0] A_CLR    = AW'(8'h13);
  localparam logic [AW-1:0] A_ECLR   = AW'(8'h14);
  localparam logic [AW-1:0] A_CFG    = AW'(8'h1A);
  localparam logic [AW-1:0] A_LIM0   = AW'(8'h1C);
  localparam logic [AW-1:0] A_LIMEND = AW'(8'h23);
  localparam logic [AW-1:0] A_TLO    = AW'(8'h31);
  localparam logic [AW-1:0] A_THI    = AW'(8'h32);
  localparam logic [AW-1:0] A_STAT   = AW'(8'h33);
  localparam logic [DW-1:0] CAP_VAL  = DW'(8'h02);

  logic signed [TW-1:0] lim_q [NLIM];
  logic signed [TW-1:0] temp_q;
  logic [3:0]           status_q;
  logic                 off_q;
  logic [3:0]           page_q;

  logic [AW-1:0] loff;
  logic [1:0]    lidx;
  logic          lim_hit;
  logic          accept;
  logic [3:0]    set_bits;
  logic [3:0]    clr_mask;
  logic signed [TW-1:0] s;

  assign s        = $signed(smp_value);
  assign accept   = smp_valid && !off_q;
  assign loff     = reg_addr - A_LIM0;
  assign lidx     = loff[2:1];
  assign lim_hit  = (reg_addr >= A_LIM0) && (reg_addr <= A_LIMEND);
  assign clr_mask = (reg_wr && reg_addr == A_CLR) ? reg_wdata[3:0] : 4'h0;

  assign set_bits[0] = accept && (s > lim_q[0]);
  assign set_bits[1] = accept && (s < lim_q[1]);
  assign set_bits[2] = accept && (s > lim_q[2]);
  assign set_bits[3] = accept && (s < lim_q[3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLIM; i++) lim_q[i] <= '0;
      temp_q   <= '0;
      status_q <= '0;
      off_q    <= 1'b0;
      page_q   <= '0;
    end else begin
      if (accept) temp_q <= s;
      status_q <= (status_q & ~clr_mask) | set_bits;
      if (reg_wr) begin
        if (reg_addr == A_CFG)  off_q  <= reg_wdata[0];
        if (reg_addr == A_PAGE) page_q <= reg_wdata[3:0];
        if (lim_hit) begin
          if (!loff[0]) lim_q[lidx][LOW_BITS-1:0] <= reg_wdata[DW-1:2];
          else          lim_q[lidx][TW-1:LOW_BITS] <= reg_wdata[HIGH_BITS-1:0];
        end
      end
    end
  end

  function automatic logic [DW-1:0] lo_byte(input logic [TW-1:0] v);
    return {v[LOW_BITS-1:0], 2'b00};
  endfunction

  function automatic logic [DW-1:0] hi_byte(input logic [TW-1:0] v);
    return {{(DW-HIGH_BITS){1'b0}}, v[TW-1:LOW_BITS]};
  endfunction

  always_comb begin
    reg_rdata = '0;
    if (lim_hit)
      reg_rdata = loff[0] ? hi_byte(lim_q[lidx]) : lo_byte(lim_q[lidx]);
    else begin
      case (reg_addr)
        A_CAP:  reg_rdata = CAP_VAL;
        A_PAGE: reg_rdata = {4'h0, page_q};
        A_CFG:  reg_rdata = {{(DW-1){1'b0}}, off_q};
        A_TLO:  reg_rdata = lo_byte(temp_q);
        A_THI:  reg_rdata = hi_byte(temp_q);
        A_STAT: reg_rdata = {4'h0, status_q};
        A_CLR, A_ECLR: reg_rdata = '0;
        default: reg_rdata = '0;
      endcase
    end
  end

  logic [3:0] keep_bits;
  assign keep_bits = status_q & ~clr_mask;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(keep_bits)) == $past(keep_bits))); // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !off_q && (s > lim_q[0]) && clr_mask[0]) |=> status_q[0]); // R7

  AST_OFF_FREEZES_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |=> $stable(temp_q)); // R8

  AST_OFF_NO_NEW_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |=> ((status_q & ~$past(status_q)) == 4'h0)); // R8

  AST_TEMP_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_TLO) |-> (reg_rdata[1:0] == 2'b00)); // R2

  AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CFG) |-> (reg_rdata[DW-1:1] == '0)); // R8

endmodule

// File: tb/tb_thermal_limit_regs.sv
module tb_thermal_limit_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [10:0] smp_value = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  thermal_limit_regs dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_value(smp_value),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] enc(input int v);
    logic [10:0] t;
    t = v[10:0];
    return {3'b000, t, 2'b00};
  endfunction

  task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr_lim(input logic [7:0] a, input int v);
    logic [15:0] w;
    w = enc(v);
    wr(a, w[7:0]);
    wr(a + 8'd1, w[15:8]);
  endtask

  task automatic sample(input int v);
    @(negedge clk);
    smp_valid = 1'b1; smp_value = v[10:0];
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check8(req, $sformatf("addr 0x%02h", a), d, exp);
  endtask

  task automatic chk_temp(input string req, input int v);
    logic [15:0] w;
    w = enc(v);
    chk_reg(req, 8'h31, w[7:0]);
    chk_reg(req, 8'h32, w[15:8]);
  endtask

  task automatic t_reset;
    chk_reg("R1", 8'h31, 8'h00); chk_reg("R1", 8'h32, 8'h00);
    chk_reg("R1", 8'h33, 8'h00); chk_reg("R1", 8'h1A, 8'h00);
    chk_reg("R1", 8'h0B, 8'h00); chk_reg("R1", 8'h05, 8'h02);
    for (int a = 8'h1C; a <= 8'h23; a++) chk_reg("R1", a[7:0], 8'h00);
  endtask

  task automatic t_limit_mask;
    wr(8'h1C, 8'hFF); wr(8'h1D, 8'hFF);
    chk_reg("R3", 8'h1C, 8'hFC);
    chk_reg("R3", 8'h1D, 8'h1F);
    wr_lim(8'h1C, 200); wr_lim(8'h1E, 40); wr_lim(8'h20, 320); wr_lim(8'h22, -20);
    chk_reg("R3", 8'h1E, 8'hA0); chk_reg("R3", 8'h1F, 8'h00);
    chk_reg("R3", 8'h22, 8'hB0); chk_reg("R3", 8'h23, 8'h1F);
  endtask

  task automatic t_compare;
    sample(100);
    chk_temp("R2", 100);
    chk_reg("R4", 8'h33, 8'h00);
    sample(200);
    chk_reg("R4", 8'h33, 8'h00);
    sample(201);
    chk_reg("R4", 8'h33, 8'h01);
    sample(100);
    chk_reg("R6", 8'h33, 8'h01);
    wr(8'h13, 8'h01);
    chk_reg("R6", 8'h33, 8'h00);
    chk_reg("R6", 8'h13, 8'h00);
    chk_reg("R6", 8'h14, 8'h00);
    sample(40);
    chk_reg("R4", 8'h33, 8'h00);
    sample(39);
    chk_reg("R4", 8'h33, 8'h02);
    wr(8'h13, 8'h0F);
  endtask

  task automatic t_critical;
    sample(321);
    chk_reg("R5", 8'h33, 8'h05);
    wr(8'h13, 8'h0F);
    sample(-20);
    chk_reg("R5", 8'h33, 8'h02);
    sample(-21);
    chk_reg("R5", 8'h33, 8'h0A);
    chk_temp("R2", -21);
    wr(8'h13, 8'h02);
    chk_reg("R6", 8'h33, 8'h08);
    wr(8'h13, 8'h0F);
    sample(-1024); chk_temp("R2", -1024);
    sample(1023);  chk_temp("R2", 1023);
    wr(8'h13, 8'h0F);
    chk_reg("R6", 8'h33, 8'h00);
  endtask

  task automatic t_race;
    @(negedge clk);
    smp_valid = 1'b1; smp_value = 11'd201;
    reg_wr = 1'b1; reg_addr = 8'h13; reg_wdata = 8'h0F;
    @(posedge clk); #1;
    smp_valid = 1'b0; reg_wr = 1'b0;
    chk_reg("R7", 8'h33, 8'h01);
    wr(8'h13, 8'h0F);
  endtask

  task automatic t_disable;
    sample(100);
    wr(8'h1A, 8'hFF);
    chk_reg("R8", 8'h1A, 8'h01);
    sample(321);
    chk_temp("R8", 100);
    chk_reg("R8", 8'h33, 8'h00);
    wr(8'h1A, 8'h00);
    sample(321);
    chk_reg("R8", 8'h33, 8'h05);
    chk_temp("R8", 321);
    wr(8'h13, 8'h0F);
  endtask

  task automatic t_readonly;
    wr(8'h31, 8'h55); wr(8'h32, 8'h55);
    wr(8'h33, 8'h0F); wr(8'h05, 8'hFF); wr(8'h14, 8'hFF);
    chk_temp("R9", 321);
    chk_reg("R9", 8'h33, 8'h00);
    chk_reg("R9", 8'h05, 8'h02);
    chk_reg("R9", 8'h14, 8'h00);
  endtask

  task automatic t_page;
    wr(8'h0B, 8'hFF);
    chk_reg("R10", 8'h0B, 8'h0F);
    wr(8'h0B, 8'h05);
    chk_reg("R10", 8'h0B, 8'h05);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_limit_mask();
    t_compare();
    t_critical();
    t_race();
    t_disable();
    t_readonly();
    t_page();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule